// File: doc/BRIEF.md
# Shared Address/GPIO Port Controller

This block runs one byte-wide microcontroller port whose pads are shared with the upper or lower bits of the external address bus. A small synchronous register bus gives access to five registers: a direction register that can be written but not read back, a read/write output latch, a read-only view of the pins, and two read/write pad-control registers for pull-up enable and open-drain enable. The pad-control registers are only stored and sent to the pad ring.

A three-bit operating-mode input decides where each pin takes its output from. In modes 4 and 5 every pin drives an address bit. In mode 6 the direction bit chooses between an address output and an input. In mode 7 the direction bit chooses between driving the output latch and an input. In modes 0 to 3 every pin is an input.

The reset inputs act in different ways. A power-on reset or hardware standby clears the direction register. A manual reset leaves the direction register as it is. In software standby, a hold input decides whether address pins keep driving the last address or release the pad.

Top module: `shared_addr_port`

## Requirements
- R1: After power-on reset (rst_n low), all registers read 0x00, rdata is 0x00, and in mode 7 pin_oe, pin_out, pull_en and odrn_en are all 0x00.
- R2: Register index 0 is the direction register. A write there stores the value. A read of index 0 returns 0x00 on rdata in the cycle after the read strobe.
- R3: Index 1 (output latch), index 3 (pull-up enable) and index 4 (open-drain enable) read back what was last written. Index 3 drives pull_en and index 4 drives odrn_en, starting from the clock edge of the write.
- R4: In modes 4 and 5, outside both standby states, pin_oe is all ones and pin_out equals addr_in, whatever the direction register holds.
- R5: In mode 6, pin_oe equals the direction register and pin_out equals addr_in on enabled bits. A pin that is not enabled always shows pin_out 0.
- R6: In mode 7, pin_oe equals the direction register and pin_out equals the output latch ANDed with the direction register.
- R7: In modes 0 to 3, pin_oe is 0x00.
- R8: A read of index 2 returns the output latch bit for pins that are general outputs. For all other pins it returns pin_in after a two-flop synchronizer.
- R9: A one-cycle manual_rst clears the output latch and both pad-control registers and keeps the direction register. A direction write in the same cycle still takes effect.
- R10: While hw_stby is high, pin_oe is 0x00. The direction, latch and pad-control registers are cleared, and this clear wins over a write in the same cycle.
- R11: In software standby with stby_hold=1, address pins keep driving the addr_in value captured on the last clock edge before standby, and later changes of addr_in are ignored. With stby_hold=0, address pins have pin_oe 0. General-output pins are not affected by software standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| manual_rst | input | 1 | Manual reset, synchronous, active high |
| hw_stby | input | 1 | Hardware standby, active high |
| sw_stby | input | 1 | Software standby, active high |
| stby_hold | input | 1 | 1: address pins keep driving in software standby; 0: they release |
| mode | input | 3 | Operating mode |
| addr_in | input | WIDTH | Address bits from the bus controller |
| pin_in | input | WIDTH | Pad input values, asynchronous |
| cs | input | 1 | Register bus select |
| we | input | 1 | Register bus write strobe |
| idx | input | 3 | Register index |
| wdata | input | WIDTH | Register write data |
| rdata | output | WIDTH | Registered read data |
| pin_oe | output | WIDTH | Per-pin output enable |
| pin_out | output | WIDTH | Per-pin output value |
| pull_en | output | WIDTH | Pull-up enables to the pads |
| odrn_en | output | WIDTH | Open-drain enables to the pads |

## Verification
Two pairs of events can arrive in the same cycle. A bus write to the direction register can coincide with a manual reset, and it can also coincide with the rising edge of hardware standby. The bench drives the write strobe and the reset input together for one cycle in each case. It then judges the result from the pin output enables in mode 7: with the manual reset the written direction must appear, and with hardware standby the cleared value must remain. A third case checks that a change of addr_in during software standby does not reach the address pins.

// File: rtl/apm_pkg.sv
package apm_pkg;

   localparam int IDX_W = 3;

   typedef enum logic [IDX_W-1:0] {
      IDX_DIR  = 3'd0,
      IDX_DATA = 3'd1,
      IDX_PORT = 3'd2,
      IDX_PULL = 3'd3,
      IDX_ODRN = 3'd4
   } reg_idx_e;

   typedef enum logic [1:0] {
      SRC_IN   = 2'd0,
      SRC_ADDR = 2'd1,
      SRC_DATA = 2'd2
   } pin_src_e;

   // output source of one pin from the operating mode and its direction bit
   function automatic pin_src_e pick_src(input logic [2:0] mode, input logic dir_bit);
      pin_src_e s;
      case (mode)
         3'd4, 3'd5: s = SRC_ADDR;
         3'd6:       s = dir_bit ? SRC_ADDR : SRC_IN;
         3'd7:       s = dir_bit ? SRC_DATA : SRC_IN;
         default:    s = SRC_IN;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/apm_sync.sv
module apm_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[0] <= '0;
      else        st[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st[s] <= '0;
         else        st[s] <= st[s-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/apm_regs.sv
module apm_regs
   import apm_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             manual_rst,
   input  logic             hw_stby,
   input  logic             cs,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] pin_view,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] data_q,
   output logic [WIDTH-1:0] pull_q,
   output logic [WIDTH-1:0] odrn_q,
   output logic [WIDTH-1:0] rdata
);
   logic             wr;
   logic             clr_soft;
   logic [WIDTH-1:0] rd_mux;

   assign wr       = cs && we;
   assign clr_soft = hw_stby || manual_rst;

   // direction: cleared only by power-on reset or hardware standby
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                dir_q <= '0;
      else if (hw_stby)                          dir_q <= '0;
      else if (wr && reg_idx_e'(idx) == IDX_DIR) dir_q <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         pull_q <= '0;
         odrn_q <= '0;
      end else if (clr_soft) begin
         data_q <= '0;
         pull_q <= '0;
         odrn_q <= '0;
      end else if (wr) begin
         case (reg_idx_e'(idx))
            IDX_DATA: data_q <= wdata;
            IDX_PULL: pull_q <= wdata;
            IDX_ODRN: odrn_q <= wdata;
            default:  ;
         endcase
      end
   end

   // the direction register is not readable: it falls into the zero default
   always_comb begin
      case (reg_idx_e'(idx))
         IDX_DATA: rd_mux = data_q;
         IDX_PORT: rd_mux = pin_view;
         IDX_PULL: rd_mux = pull_q;
         IDX_ODRN: rd_mux = odrn_q;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rdata <= '0;
      else if (cs && !we) rdata <= rd_mux;
   end
endmodule

// File: rtl/apm_pin_sel.sv
module apm_pin_sel
   import apm_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] data_q,
   input  logic [WIDTH-1:0] addr_in,
   input  logic             sw_stby,
   input  logic             stby_hold,
   input  logic             hw_stby,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] gpo_mask
);
   logic [WIDTH-1:0] addr_q;
   logic [WIDTH-1:0] addr_v;
   logic             addr_drive;

   // freeze the address for the whole software standby period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        addr_q <= '0;
      else if (!sw_stby) addr_q <= addr_in;
   end

   assign addr_v     = sw_stby ? addr_q : addr_in;
   assign addr_drive = !hw_stby && !(sw_stby && !stby_hold);

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      pin_src_e src;
      assign src = pick_src(mode, dir_q[i]);
      always_comb begin
         pin_oe[i]   = 1'b0;
         pin_out[i]  = 1'b0;
         gpo_mask[i] = 1'b0;
         case (src)
            SRC_ADDR: begin
               pin_oe[i]  = addr_drive;
               pin_out[i] = addr_drive & addr_v[i];
            end
            SRC_DATA: begin
               gpo_mask[i] = 1'b1;
               pin_oe[i]   = !hw_stby;
               pin_out[i]  = !hw_stby & data_q[i];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/shared_addr_port.sv
module shared_addr_port
   import apm_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             manual_rst,
   input  logic             hw_stby,
   input  logic             sw_stby,
   input  logic             stby_hold,
   input  logic [2:0]       mode,
   input  logic [WIDTH-1:0] addr_in,
   input  logic [WIDTH-1:0] pin_in,
   input  logic             cs,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pull_en,
   output logic [WIDTH-1:0] odrn_en
);
   if (WIDTH < 1) begin : g_bad_width
      $error("shared_addr_port: WIDTH must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("shared_addr_port: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] dir_q, data_q, pin_sync, gpo_mask, pin_view;

   apm_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
   );

   assign pin_view = (data_q & gpo_mask) | (pin_sync & ~gpo_mask);

   apm_regs #(.WIDTH(WIDTH)) u_regs (
      .clk(clk), .rst_n(rst_n), .manual_rst(manual_rst), .hw_stby(hw_stby),
      .cs(cs), .we(we), .idx(idx), .wdata(wdata), .pin_view(pin_view),
      .dir_q(dir_q), .data_q(data_q), .pull_q(pull_en), .odrn_q(odrn_en),
      .rdata(rdata)
   );

   apm_pin_sel #(.WIDTH(WIDTH)) u_sel (
      .clk(clk), .rst_n(rst_n), .mode(mode), .dir_q(dir_q), .data_q(data_q),
      .addr_in(addr_in), .sw_stby(sw_stby), .stby_hold(stby_hold),
      .hw_stby(hw_stby), .pin_oe(pin_oe), .pin_out(pin_out),
      .gpo_mask(gpo_mask)
   );
endmodule

// File: rtl/shared_addr_port_chk.sv
module shared_addr_port_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             manual_rst,
   input logic             hw_stby,
   input logic             sw_stby,
   input logic [2:0]       mode,
   input logic [WIDTH-1:0] addr_in,
   input logic             cs,
   input logic             we,
   input logic [2:0]       idx,
   input logic [WIDTH-1:0] rdata,
   input logic [WIDTH-1:0] pin_oe,
   input logic [WIDTH-1:0] pin_out,
   input logic [WIDTH-1:0] dir_q
);
   AST_HWSTBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      hw_stby |-> pin_oe == '0); // R10

   AST_ADDR_MODES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == 3'd4 || mode == 3'd5) && !hw_stby && !sw_stby)
      |-> (pin_oe == '1 && pin_out == addr_in)); // R4

   AST_LOW_MODES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode < 3'd4) |-> pin_oe == '0); // R7

   AST_DIR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && !we && idx == 3'd0) |=> rdata == '0); // R2

   AST_OFF_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0); // R5

   AST_MANUAL_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (manual_rst && !hw_stby && !(cs && we && idx == 3'd0))
      |=> dir_q == $past(dir_q)); // R9
endmodule

bind shared_addr_port shared_addr_port_chk #(.WIDTH(WIDTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .manual_rst(manual_rst), .hw_stby(hw_stby),
   .sw_stby(sw_stby), .mode(mode), .addr_in(addr_in), .cs(cs), .we(we),
   .idx(idx), .rdata(rdata), .pin_oe(pin_oe), .pin_out(pin_out),
   .dir_q(dir_q)
);

// File: tb/shared_addr_port_test.sv
module shared_addr_port_test;
   localparam int W = 8;

   typedef struct {
      logic [W-1:0] val;
      string        req;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         manual_rst = 1'b0, hw_stby = 1'b0, sw_stby = 1'b0, stby_hold = 1'b1;
   logic [2:0]   mode = 3'd7;
   logic [W-1:0] addr_in = '0, pin_in = '0, wdata = '0;
   logic         cs = 1'b0, we = 1'b0;
   logic [2:0]   idx = '0;
   logic [W-1:0] rdata, pin_oe, pin_out, pull_en, odrn_en;

   int   total = 0;
   int   bad = 0;
   exp_t sb[$];
   logic rd_seen = 1'b0;

   always #4 clk = ~clk;

   shared_addr_port uut (
      .clk(clk), .rst_n(rst_n), .manual_rst(manual_rst), .hw_stby(hw_stby),
      .sw_stby(sw_stby), .stby_hold(stby_hold), .mode(mode), .addr_in(addr_in),
      .pin_in(pin_in), .cs(cs), .we(we), .idx(idx), .wdata(wdata),
      .rdata(rdata), .pin_oe(pin_oe), .pin_out(pin_out), .pull_en(pull_en),
      .odrn_en(odrn_en)
   );

   task automatic check(input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor: compares rdata one edge after a read strobe
   always @(posedge clk) rd_seen <= rst_n && cs && !we;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (sb.size() == 0) begin
            check("SB", "unexpected read", rdata, '0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, "rdata", rdata, e.val);
         end
      end
   end

   task automatic tick(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] i, input logic [W-1:0] d);
      cs = 1'b1; we = 1'b1; idx = i; wdata = d;
      tick();
      cs = 1'b0; we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] i, input logic [W-1:0] exp, input string req);
      exp_t e;
      e.val = exp; e.req = req;
      sb.push_back(e);
      cs = 1'b1; we = 1'b0; idx = i;
      tick();
      cs = 1'b0;
   endtask

   task automatic pins(input string req, input logic [W-1:0] oe, input logic [W-1:0] o);
      check(req, "pin_oe", pin_oe, oe);
      check(req, "pin_out", pin_out, o);
   endtask

   task automatic finish_run();
      check("SB", "queue left", W'(sb.size()), '0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick();
      // R1 reset state
      check("R1", "rdata", rdata, 8'h00);
      pins("R1", 8'h00, 8'h00);
      check("R1", "pull_en", pull_en, 8'h00);
      check("R1", "odrn_en", odrn_en, 8'h00);
      rd(3'd1, 8'h00, "R1");

      // R6 general outputs in mode 7; R2 direction not readable
      wr(3'd0, 8'hF0);
      wr(3'd1, 8'hA5);
      pins("R6", 8'hF0, 8'hA0);
      rd(3'd0, 8'h00, "R2");
      rd(3'd1, 8'hA5, "R3");

      // R3 pad controls
      wr(3'd3, 8'h3C);
      wr(3'd4, 8'hC3);
      check("R3", "pull_en", pull_en, 8'h3C);
      check("R3", "odrn_en", odrn_en, 8'hC3);
      rd(3'd3, 8'h3C, "R3");
      rd(3'd4, 8'hC3, "R3");

      // R8 port view mixes latch and synchronized pins
      pin_in = 8'h5A;
      tick(3);
      rd(3'd2, 8'hAA, "R8");

      // R5 mode 6
      mode = 3'd6; addr_in = 8'h96;
      tick();
      pins("R5", 8'hF0, 8'h90);

      // R4 modes 4 and 5 ignore direction
      mode = 3'd4;
      tick();
      pins("R4", 8'hFF, 8'h96);
      mode = 3'd5; addr_in = 8'h3C;
      tick();
      pins("R4", 8'hFF, 8'h3C);

      // R7 low modes
      mode = 3'd2;
      tick();
      pins("R7", 8'h00, 8'h00);

      // R9 manual reset with a concurrent direction write
      mode = 3'd7;
      manual_rst = 1'b1; cs = 1'b1; we = 1'b1; idx = 3'd0; wdata = 8'h0F;
      tick();
      manual_rst = 1'b0; cs = 1'b0; we = 1'b0;
      pins("R9", 8'h0F, 8'h00);
      check("R9", "pull_en", pull_en, 8'h00);
      check("R9", "odrn_en", odrn_en, 8'h00);
      rd(3'd1, 8'h00, "R9");
      wr(3'd1, 8'h0B);
      pins("R9", 8'h0F, 8'h0B);
      manual_rst = 1'b1;
      tick();
      manual_rst = 1'b0;
      pins("R9", 8'h0F, 8'h00);

      // R10 hardware standby wins over a concurrent write
      wr(3'd3, 8'h77);
      mode = 3'd4;
      hw_stby = 1'b1; cs = 1'b1; we = 1'b1; idx = 3'd0; wdata = 8'hFF;
      tick();
      cs = 1'b0; we = 1'b0;
      pins("R10", 8'h00, 8'h00);
      check("R10", "pull_en", pull_en, 8'h00);
      hw_stby = 1'b0; mode = 3'd7;
      tick();
      pins("R10", 8'h00, 8'h00);

      // R11 software standby
      mode = 3'd4; addr_in = 8'h5C;
      tick();
      sw_stby = 1'b1; stby_hold = 1'b1; addr_in = 8'h11;
      tick();
      pins("R11", 8'hFF, 8'h5C);
      tick();
      pins("R11", 8'hFF, 8'h5C);
      stby_hold = 1'b0;
      tick();
      pins("R11", 8'h00, 8'h00);
      mode = 3'd7;
      wr(3'd0, 8'h03);
      wr(3'd1, 8'h01);
      pins("R11", 8'h03, 8'h01);
      sw_stby = 1'b0;
      tick(2);
      finish_run();
   end
endmodule